// File: doc/BRIEF.md
# Memory Zero-Fill Engine

This block clears a contiguous stretch of memory on request from a host. The host programs an inclusive start address and an inclusive end address into two 32-bit registers, then writes an operation code into a command register. If the code names the clearing operation and the range is well formed, the engine walks the range and emits a series of write bursts on a memory port. Each burst carries an address, a byte length and all-zero data. The engine starts the next burst at the byte that follows the previous one, and it stops once every byte of the range has been covered.

Bursts are limited to a parameterised chunk size, 4096 bytes by default. A large range therefore becomes a chain of full chunks and ends with one shorter tail chunk. While a fill is running the engine reports busy and discards any further commands. A one-cycle done pulse marks the end of the fill. A command that cannot be accepted produces a one-cycle reject pulse and no memory traffic.

The host bus carries 32-bit words and also takes 64-bit accesses that cover two neighbouring words. A small window of plain storage words holds the two address registers alongside general scratch words.

Top module: `zf_engine`

## Requirements
- R1: After reset busy, done, reject and mem_valid are low. Every storage word, the command register and the status register read as zero.
- R2: A 32-bit write to any word in the storage window (byte offsets 0x3000 to 0x303C) is read back unchanged by a 32-bit read of the same offset. A 32-bit read places the word in host_rdata[31:0] with zeros above it.
- R3: A 64-bit write stores host_wdata[63:32] at the addressed word and host_wdata[31:0] at the word 4 bytes higher. A 64-bit read returns the addressed word in bits [63:32] and the next word in bits [31:0].
- R4: Writing 0x11 to the command register (offset 0x3800) while idle, with end (offset 0x3038) not below start (offset 0x3030), starts a fill. busy rises on the following cycle and bit 0 of the status register (offset 0x3804) reads 1 while the fill runs. The command register reads back the value that was accepted.
- R5: The fill covers end minus start plus one bytes. Every burst length is min(remaining bytes, 4096), and the first burst is addressed at start.
- R6: Each later burst address equals the previous burst address plus the previous length. The bursts together cover exactly the range, with nothing issued beyond it.
- R7: While mem_valid is high and mem_ready is low, mem_valid stays high and mem_addr and mem_len hold their values.
- R8: done is a one-cycle pulse in the cycle after the final burst handshake. busy is low in that same cycle.
- R9: A command other than 0x11, or 0x11 with end below start, while idle, produces a one-cycle reject pulse on the next cycle and no memory writes.
- R10: A command written while busy is ignored. It causes no reject and no extra bursts, and the command register is left unchanged.
- R11: mem_wdata is zero on every accepted burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access strobe; it qualifies writes |
| host_we | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | 1 = 64-bit access covering two words |
| host_addr | input | HOST_AW | Byte offset of the access |
| host_wdata | input | 64 | Write data; only [31:0] is used for 32-bit writes |
| host_rdata | output | 64 | Combinational read data for host_addr |
| mem_valid | output | 1 | Burst request pending |
| mem_ready | input | 1 | Memory accepts the pending burst |
| mem_addr | output | MEM_AW | Byte address of the burst |
| mem_len | output | log2(CHUNK_BYTES)+1 | Burst length in bytes |
| mem_wdata | output | MEM_DW | Burst data, always zero |
| busy | output | 1 | Fill in progress |
| done | output | 1 | One-cycle pulse at the end of a fill |
| reject | output | 1 | One-cycle pulse for a refused command |

## Verification
The bench goes after chunk boundaries: a single-byte range, a range of exactly one chunk, and a multi-chunk range whose tail is short and whose start is unaligned. An engine that rounded lengths, left out the +1 or failed to advance the address would produce a burst that does not match the scoreboard, or a burst the scoreboard never expected. A fully stalled and a randomly stalled memory port catch an engine that drops or alters a request before it is accepted. Commands sent while busy catch an engine that restarts or rejects instead of ignoring them. Unknown codes and reversed ranges catch an engine that writes memory anyway or does not flag the refusal.

// File: rtl/zf_pkg.sv
package zf_pkg;
    typedef enum logic [0:0] {ZF_IDLE, ZF_RUN} zf_state_e;

    localparam logic [31:0] ZF_OP_CLEAR   = 32'h0000_0011;
    localparam int          ZF_STORE_BASE = 'h3000;
    localparam int          ZF_OFF_FIRST  = 'h3030;
    localparam int          ZF_OFF_LAST   = 'h3038;
    localparam int          ZF_OFF_CMD    = 'h3800;
    localparam int          ZF_OFF_STAT   = 'h3804;
endpackage

// File: rtl/zf_regs.sv
module zf_regs
    import zf_pkg::*;
#(
    parameter int HOST_AW     = 14,
    parameter int STORE_WORDS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic               host_wide,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [63:0]        host_wdata,
    output logic [63:0]        host_rdata,
    input  logic               busy,
    output logic [31:0]        first_addr,
    output logic [31:0]        last_addr,
    output logic               cmd_wr,
    output logic [31:0]        cmd_val
);
    localparam int FIRST_IDX = (ZF_OFF_FIRST - ZF_STORE_BASE) / 4;
    localparam int LAST_IDX  = (ZF_OFF_LAST - ZF_STORE_BASE) / 4;
    localparam logic [HOST_AW-1:0] BASE_A = HOST_AW'(ZF_STORE_BASE);
    localparam logic [HOST_AW-1:0] CMD_A  = HOST_AW'(ZF_OFF_CMD);
    localparam logic [HOST_AW-1:0] STAT_A = HOST_AW'(ZF_OFF_STAT);

    typedef struct packed {
        logic [STORE_WORDS-1:0][31:0] store;
        logic [31:0]                  cmd;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [HOST_AW-1:0] off0, off1;
    logic [31:0]        val0, rd0, rd1;
    logic               wr, cmd_hit0, cmd_hit1;

    always_comb begin
        off0     = host_addr & ~HOST_AW'(3);
        off1     = off0 + HOST_AW'(4);
        wr       = host_req && host_we;
        val0     = host_wide ? host_wdata[63:32] : host_wdata[31:0];
        cmd_hit0 = off0 == CMD_A;
        cmd_hit1 = host_wide && (off1 == CMD_A);
        cmd_wr   = wr && (cmd_hit0 || cmd_hit1);
        cmd_val  = cmd_hit0 ? val0 : host_wdata[31:0];

        regs_d = regs_q;
        for (int i = 0; i < STORE_WORDS; i++) begin
            if (wr && off0 == BASE_A + HOST_AW'(i * 4))
                regs_d.store[i] = val0;
            if (wr && host_wide && off1 == BASE_A + HOST_AW'(i * 4))
                regs_d.store[i] = host_wdata[31:0];
        end
        if (cmd_wr && !busy)
            regs_d.cmd = cmd_val;

        rd0 = '0;
        rd1 = '0;
        if (off0 == CMD_A)  rd0 = regs_q.cmd;
        if (off1 == CMD_A)  rd1 = regs_q.cmd;
        if (off0 == STAT_A) rd0 = {31'b0, busy};
        if (off1 == STAT_A) rd1 = {31'b0, busy};
        for (int i = 0; i < STORE_WORDS; i++) begin
            if (off0 == BASE_A + HOST_AW'(i * 4)) rd0 = regs_q.store[i];
            if (off1 == BASE_A + HOST_AW'(i * 4)) rd1 = regs_q.store[i];
        end
        host_rdata = host_wide ? {rd0, rd1} : {32'b0, rd0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign first_addr = regs_q.store[FIRST_IDX];
    assign last_addr  = regs_q.store[LAST_IDX];
endmodule

// File: rtl/zf_seq.sv
module zf_seq
    import zf_pkg::*;
#(
    parameter int CHUNK_BYTES = 4096,
    parameter int MEM_AW      = 32,
    parameter int LEN_W       = $clog2(CHUNK_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [31:0]       cmd_val,
    input  logic [MEM_AW-1:0] first_addr,
    input  logic [MEM_AW-1:0] last_addr,
    input  logic              mem_ready,
    output logic              mem_valid,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_len,
    output logic              busy,
    output logic              done,
    output logic              reject
);
    localparam int RW = MEM_AW + 1;
    localparam logic [RW-1:0] CHUNK_R = RW'(CHUNK_BYTES);

    typedef struct packed {
        zf_state_e         state;
        logic [MEM_AW-1:0] addr;
        logic [RW-1:0]     remain;
        logic              done;
        logic              reject;
    } seq_t;

    seq_t          seq_d, seq_q;
    logic [RW-1:0] chunk_r;

    always_comb begin
        chunk_r = (seq_q.remain > CHUNK_R) ? CHUNK_R : seq_q.remain;
        seq_d        = seq_q;
        seq_d.done   = 1'b0;
        seq_d.reject = 1'b0;
        case (seq_q.state)
            ZF_IDLE: begin
                if (cmd_wr) begin
                    if (cmd_val == ZF_OP_CLEAR && last_addr >= first_addr) begin
                        seq_d.state  = ZF_RUN;
                        seq_d.addr   = first_addr;
                        seq_d.remain = {1'b0, last_addr} - {1'b0, first_addr} + RW'(1);
                    end else begin
                        seq_d.reject = 1'b1;
                    end
                end
            end
            ZF_RUN: begin
                if (mem_ready) begin
                    seq_d.addr   = seq_q.addr + chunk_r[MEM_AW-1:0];
                    seq_d.remain = seq_q.remain - chunk_r;
                    if (seq_q.remain == chunk_r) begin
                        seq_d.state = ZF_IDLE;
                        seq_d.done  = 1'b1;
                    end
                end
            end
            default: seq_d.state = ZF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{state: ZF_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign mem_valid = seq_q.state == ZF_RUN;
    assign busy      = seq_q.state == ZF_RUN;
    assign mem_addr  = seq_q.addr;
    assign mem_len   = chunk_r[LEN_W-1:0];
    assign done      = seq_q.done;
    assign reject    = seq_q.reject;
endmodule

// File: rtl/zf_engine.sv
module zf_engine
    import zf_pkg::*;
#(
    parameter int CHUNK_BYTES = 4096,
    parameter int MEM_AW      = 32,
    parameter int MEM_DW      = 64,
    parameter int HOST_AW     = 14,
    parameter int STORE_WORDS = 16,
    parameter int LEN_W       = $clog2(CHUNK_BYTES) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic               host_wide,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [63:0]        host_wdata,
    output logic [63:0]        host_rdata,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [LEN_W-1:0]   mem_len,
    output logic [MEM_DW-1:0]  mem_wdata,
    output logic               busy,
    output logic               done,
    output logic               reject
);
    logic [31:0] first_w, last_w, cmd_val_w;
    logic        cmd_wr_w;

    zf_regs #(
        .HOST_AW    (HOST_AW),
        .STORE_WORDS(STORE_WORDS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_req  (host_req),
        .host_we   (host_we),
        .host_wide (host_wide),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .busy      (busy),
        .first_addr(first_w),
        .last_addr (last_w),
        .cmd_wr    (cmd_wr_w),
        .cmd_val   (cmd_val_w)
    );

    zf_seq #(
        .CHUNK_BYTES(CHUNK_BYTES),
        .MEM_AW     (MEM_AW),
        .LEN_W      (LEN_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr_w),
        .cmd_val   (cmd_val_w),
        .first_addr(first_w[MEM_AW-1:0]),
        .last_addr (last_w[MEM_AW-1:0]),
        .mem_ready (mem_ready),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_len   (mem_len),
        .busy      (busy),
        .done      (done),
        .reject    (reject)
    );

    assign mem_wdata = '0;
endmodule

// File: rtl/zf_engine_chk.sv
module zf_engine_chk
    import zf_pkg::*;
#(
    parameter int CHUNK_BYTES = 4096,
    parameter int MEM_AW      = 32,
    parameter int HOST_AW     = 14,
    parameter int LEN_W       = $clog2(CHUNK_BYTES) + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_req,
    input logic               host_we,
    input logic               host_wide,
    input logic [HOST_AW-1:0] host_addr,
    input logic               mem_valid,
    input logic               mem_ready,
    input logic [MEM_AW-1:0]  mem_addr,
    input logic [LEN_W-1:0]   mem_len,
    input logic               busy,
    input logic               done,
    input logic               reject
);
    localparam logic [HOST_AW-1:0] CMD_A = HOST_AW'(ZF_OFF_CMD);

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_len != '0 && mem_len <= LEN_W'(CHUNK_BYTES))); // R5
    AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> (!mem_valid || mem_addr == $past(mem_addr) + MEM_AW'($past(mem_len)))); // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_len))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_valid && mem_ready) && !busy)); // R8
    AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> (!busy && !mem_valid && !done)); // R9
    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_req && host_we && !host_wide && host_addr == CMD_A) |=> !reject); // R10
endmodule

bind zf_engine zf_engine_chk #(
    .CHUNK_BYTES(CHUNK_BYTES),
    .MEM_AW     (MEM_AW),
    .HOST_AW    (HOST_AW),
    .LEN_W      (LEN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_req (host_req),
    .host_we  (host_we),
    .host_wide(host_wide),
    .host_addr(host_addr),
    .mem_valid(mem_valid),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr),
    .mem_len  (mem_len),
    .busy     (busy),
    .done     (done),
    .reject   (reject)
);

// File: tb/zf_engine_tb.sv
module zf_engine_tb;
    localparam int CHUNK = 4096;
    localparam logic [13:0] A_FIRST = 14'h3030;
    localparam logic [13:0] A_LAST  = 14'h3038;
    localparam logic [13:0] A_CMD   = 14'h3800;
    localparam logic [13:0] A_STAT  = 14'h3804;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        host_req = 0, host_we = 0, host_wide = 0;
    logic [13:0] host_addr = '0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        mem_valid, mem_ready = 0;
    logic [31:0] mem_addr;
    logic [12:0] mem_len;
    logic [63:0] mem_wdata;
    logic        busy, done, reject;

    always #5 clk = ~clk;

    zf_engine u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_wide(host_wide), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_wdata(mem_wdata),
        .busy(busy), .done(done), .reject(reject)
    );

    int n_checks = 0, n_fail = 0;
    int hs_cnt = 0, done_cnt = 0, rej_cnt = 0;
    int rdy_mode = 0;
    bit finished = 0;
    logic [63:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: drives mem_ready and compares bursts
    initial begin : monitor
        logic [15:0] lfsr = 16'hACE1;
        bit prev_stall = 0, prev_hs = 0;
        logic [31:0] prev_addr = '0;
        logic [12:0] prev_len = '0;
        forever begin
            @(negedge clk);
            case (rdy_mode)
                0: mem_ready = 1'b1;
                1: mem_ready = lfsr[0] ^ lfsr[3];
                default: mem_ready = 1'b0;
            endcase
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            #1;
            if (rst_n) begin
                if (prev_stall)
                    chk(mem_valid && mem_addr == prev_addr && mem_len == prev_len,
                        "R7 held request", {mem_addr, 19'b0, mem_len}, {prev_addr, 19'b0, prev_len});
                if (done) begin
                    done_cnt++;
                    chk(!busy && prev_hs, "R8 done after final handshake", {busy, prev_hs}, 2'b01);
                    chk(exp_q.size() == 0, "R6 bursts missing at done", exp_q.size(), 0);
                end
                if (reject) rej_cnt++;
                if (mem_valid && mem_ready) begin
                    hs_cnt++;
                    chk(mem_wdata == '0, "R11 zero data", mem_wdata, 0);
                    if (exp_q.size() == 0) begin
                        chk(0, "R6 unexpected burst", {mem_addr, 19'b0, mem_len}, 0);
                    end else begin
                        logic [63:0] e;
                        e = exp_q.pop_front();
                        chk({mem_addr, 19'b0, mem_len} == e, "R5/R6 burst addr/len",
                            {mem_addr, 19'b0, mem_len}, e);
                    end
                end
                prev_stall = mem_valid && !mem_ready;
                prev_hs    = mem_valid && mem_ready;
                prev_addr  = mem_addr;
                prev_len   = mem_len;
            end
        end
    end

    task automatic wr32(input logic [13:0] a, input logic [31:0] v);
        @(negedge clk);
        host_req = 1; host_we = 1; host_wide = 0; host_addr = a; host_wdata = {32'h0, v};
        @(negedge clk);
        host_req = 0; host_we = 0;
        #2;
    endtask

    task automatic wr64(input logic [13:0] a, input logic [63:0] v);
        @(negedge clk);
        host_req = 1; host_we = 1; host_wide = 1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_req = 0; host_we = 0; host_wide = 0;
        #2;
    endtask

    task automatic rd(input logic [13:0] a, input bit wide, output logic [63:0] v);
        @(negedge clk);
        host_addr = a; host_wide = wide;
        #2;
        v = host_rdata;
        host_wide = 0;
    endtask

    // driver: pushes the expected bursts, then programs and starts the fill
    task automatic push_range(input logic [31:0] f, input logic [31:0] l);
        logic [32:0] rem = {1'b0, l} - {1'b0, f} + 33'd1;
        logic [31:0] a = f;
        while (rem != 0) begin
            logic [32:0] c = (rem > 33'(CHUNK)) ? 33'(CHUNK) : rem;
            exp_q.push_back({a, 19'b0, c[12:0]});
            a = a + c[31:0];
            rem = rem - c;
        end
    endtask

    task automatic fill(input logic [31:0] f, input logic [31:0] l);
        push_range(f, l);
        wr32(A_FIRST, f);
        wr32(A_LAST, l);
        wr32(A_CMD, 32'h11);
    endtask

    task automatic wait_done(input int target, input string req);
        int n = 0;
        while (done_cnt < target && n < 20000) begin
            @(negedge clk); #2; n++;
        end
        chk(done_cnt == target, req, done_cnt, target);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] v;
        int hs0, rj0, dn0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        // R1 reset state
        chk(!busy && !done && !reject && !mem_valid, "R1 outputs idle", {busy, done, reject, mem_valid}, 0);
        rd(A_FIRST, 0, v); chk(v == 0, "R1 start reg zero", v, 0);
        rd(A_STAT, 0, v);  chk(v == 0, "R1 status zero", v, 0);
        rd(A_CMD, 0, v);   chk(v == 0, "R1 command zero", v, 0);

        // R2 plain storage
        wr32(14'h3000, 32'hA5A5_1234);
        wr32(14'h303C, 32'h0BAD_F00D);
        rd(14'h3000, 0, v); chk(v == 64'hA5A5_1234, "R2 word 0x3000", v, 64'hA5A5_1234);
        rd(14'h303C, 0, v); chk(v == 64'h0BAD_F00D, "R2 word 0x303C", v, 64'h0BAD_F00D);

        // R3 64-bit split
        wr64(14'h3010, 64'h1122_3344_5566_7788);
        rd(14'h3010, 0, v); chk(v == 64'h1122_3344, "R3 upper at addressed word", v, 64'h1122_3344);
        rd(14'h3014, 0, v); chk(v == 64'h5566_7788, "R3 lower at next word", v, 64'h5566_7788);
        rd(14'h3010, 1, v); chk(v == 64'h1122_3344_5566_7788, "R3 wide read", v, 64'h1122_3344_5566_7788);

        // R5/R6 multi-chunk, short tail, ready always high
        rdy_mode = 0;
        fill(32'h0000_1000, 32'h0000_1000 + 32'd10000 - 1);
        wait_done(1, "R6 three-chunk fill done");
        chk(!busy, "R8 busy low after fill", busy, 0);
        // single byte
        fill(32'h0000_0020, 32'h0000_0020);
        wait_done(2, "R5 one-byte fill done");
        // exactly one chunk near top of address space
        fill(32'hFFFF_F000, 32'hFFFF_FFFF);
        wait_done(3, "R5 exact chunk fill done");
        // unaligned two full chunks, stalled port
        rdy_mode = 1;
        fill(32'h0000_0123, 32'h0000_0123 + 32'd8192 - 1);
        wait_done(4, "R7 two-chunk fill under stalls");
        fill(32'h0001_0001, 32'h0001_0001 + 32'd12289 - 1);
        wait_done(5, "R6 four-chunk fill under stalls");

        // R4 / R10 busy behaviour with port stalled
        rdy_mode = 2;
        hs0 = hs_cnt; rj0 = rej_cnt;
        fill(32'h0000_8000, 32'h0000_8000 + 32'd5000 - 1);
        chk(busy, "R4 busy after command", busy, 1);
        rd(A_STAT, 0, v); chk(v == 1, "R4 status busy bit", v, 1);
        rd(A_CMD, 0, v);  chk(v == 32'h11, "R4 command readback", v, 32'h11);
        wr32(A_FIRST, 32'h0000_9000);
        wr32(A_CMD, 32'h11);
        wr32(A_CMD, 32'h05);
        chk(rej_cnt == rj0, "R10 no reject while busy", rej_cnt, rj0);
        rd(A_CMD, 0, v);  chk(v == 32'h11, "R10 command unchanged", v, 32'h11);
        chk(mem_valid && mem_addr == 32'h8000, "R10 current burst kept", mem_addr, 32'h8000);
        rdy_mode = 0;
        wait_done(6, "R10 original fill completes");
        repeat (10) @(negedge clk);
        #2;
        chk(hs_cnt == hs0 + 2 && !mem_valid, "R10 no extra bursts", hs_cnt, hs0 + 2);

        // R9 rejects
        hs0 = hs_cnt; rj0 = rej_cnt; dn0 = done_cnt;
        wr32(A_CMD, 32'h22);
        chk(rej_cnt == rj0 + 1, "R9 unknown code rejected", rej_cnt, rj0 + 1);
        wr32(A_FIRST, 32'h0000_0500);
        wr32(A_LAST, 32'h0000_04FF);
        wr32(A_CMD, 32'h11);
        chk(rej_cnt == rj0 + 2, "R9 reversed range rejected", rej_cnt, rj0 + 2);
        repeat (5) @(negedge clk);
        #2;
        chk(hs_cnt == hs0 && done_cnt == dn0 && !busy, "R9 no writes after reject", hs_cnt, hs0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule